// File: doc/BRIEF.md
# Flash Command Register Controller

This block is the device-side command interface of a small parallel flash memory model. A host drives an address bus, a write data bus and three active-low strobes (chip enable, write enable, output enable), plus a flag that says the high programming voltage is present. Every write cycle is captured from the strobes, its data byte is decoded as a command, and an internal state machine steps through read, identifier, setup, pulse and verify phases. A register array stands in for the flash cells.

Program and erase each take two command writes. The first write arms the operation. The second write starts a timed pulse, and an internal stop timer ends that pulse after a fixed number of clock cycles. A verify command ends the operation and places the byte at the verify address on the read path for comparison. When the high voltage flag is low, every write is ignored and the block acts as a plain read-only memory.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset the block is in read mode and every byte of the model array reads FFh.
- R2: The output enable flag data_oe_o is 1 exactly when ce_n_i=0, oe_n_i=0 and we_n_i=1. data_o then carries the selected byte. Otherwise data_o is 00h (standby or output disabled).
- R3: While vpp_hi_i=0, command and data writes change neither the array nor the mode. Dropping vpp_hi_i returns the block to read mode.
- R4: A write cycle is active while ce_n_i and we_n_i are both low. The address is taken when the later of the two strobes falls. The data byte is the value present in the last active cycle, before the first strobe rises.
- R5: Command 40h followed by a data write to address A starts a program pulse. When the pulse completes, byte A becomes its old value ANDed with the written data. Other bytes are unchanged.
- R6: Erase starts only when code 20h is written twice in succession. A 20h followed by any other code does not erase, and the second code is decoded as a fresh command.
- R7: A completed erase pulse sets every byte of the array to FFh.
- R8: The stop timer ends a program pulse after PGM_CYCLES clock cycles and an erase pulse after ERASE_CYCLES clock cycles. The array changes only at the end of the pulse. A write that arrives before then ends the pulse with no change to the array.
- R9: Codes C0h (program verify) and A0h (erase verify) make every read return the byte at the address of the verify write, whatever the read address.
- R10: Code 90h selects identifier mode. A read with address bit 0 = 0 returns MFR_CODE, and a read with bit 0 = 1 returns DEV_CODE.
- R11: Codes 00h and FFh, and any code not listed in R5, R6, R9 and R10, return the block to read mode. In read mode, reads return the array byte at the presented address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | ADDR_W | Byte address |
| data_i | input | 8 | Write data / command byte |
| ce_n_i | input | 1 | Chip enable, active low |
| we_n_i | input | 1 | Write enable, active low |
| oe_n_i | input | 1 | Output enable, active low |
| vpp_hi_i | input | 1 | High programming voltage present |
| data_o | output | 8 | Read data |
| data_oe_o | output | 1 | Read data valid / bus drive enable |

## Verification
The read path is combinational from the address and the current mode, so a read result is due in the same cycle the address is presented. The bench samples it at the falling clock edge of that cycle. A write becomes a mode change on the second rising edge after its closing strobe: one register in capture and one in the state machine. A program or erase result lands a further PGM_CYCLES or ERASE_CYCLES edges later. Each write task therefore idles three cycles after it ends, and the bench waits a margin beyond the pulse length before reading back. To show the stop timer holds the array steady, the bench also reads and aborts inside the pulse, well short of its end.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    typedef logic [7:0] byte_t;

    localparam byte_t CMD_READ      = 8'h00;
    localparam byte_t CMD_ERASE     = 8'h20;
    localparam byte_t CMD_ERASE_VFY = 8'hA0;
    localparam byte_t CMD_PGM       = 8'h40;
    localparam byte_t CMD_PGM_VFY   = 8'hC0;
    localparam byte_t CMD_IDENT     = 8'h90;
    localparam byte_t CMD_RESET     = 8'hFF;

    typedef enum logic [3:0] {
        M_READ,
        M_IDENT,
        M_ERASE_ARM,
        M_ERASE_PULSE,
        M_ERASE_HOLD,
        M_ERASE_VFY,
        M_PGM_ARM,
        M_PGM_PULSE,
        M_PGM_HOLD,
        M_PGM_VFY
    } mode_e;

    typedef struct packed {
        logic  valid;
        byte_t data;
    } wr_evt_t;

    function automatic mode_e decode_cmd(input byte_t code);
        case (code)
            CMD_ERASE:     return M_ERASE_ARM;
            CMD_ERASE_VFY: return M_ERASE_VFY;
            CMD_PGM:       return M_PGM_ARM;
            CMD_PGM_VFY:   return M_PGM_VFY;
            CMD_IDENT:     return M_IDENT;
            default:       return M_READ;
        endcase
    endfunction

    function automatic logic is_verify(input mode_e m);
        return (m == M_PGM_VFY) || (m == M_ERASE_VFY);
    endfunction

endpackage

// File: rtl/flash_wr_capture.sv
module flash_wr_capture
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr_i,
    input  byte_t             data_i,
    input  logic              ce_n_i,
    input  logic              we_n_i,
    output wr_evt_t           evt_o,
    output logic [ADDR_W-1:0] addr_o
);

    logic              act;
    logic              act_q;
    logic [ADDR_W-1:0] addr_q;
    byte_t             data_q;

    assign act = ~ce_n_i & ~we_n_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q  <= 1'b0;
            addr_q <= '0;
            data_q <= '0;
            evt_o  <= '0;
        end else begin
            act_q <= act;
            if (act && !act_q) addr_q <= addr_i;
            if (act) data_q <= data_i;
            evt_o.valid <= act_q && !act;
            evt_o.data  <= data_q;
        end
    end

    assign addr_o = addr_q;

    // R4: one event per write cycle
    a_r4_single_event: assert property (@(posedge clk) disable iff (rst)
        evt_o.valid |=> !evt_o.valid);

    // R4: address stays fixed once the write cycle is open
    a_r4_addr_held: assert property (@(posedge clk) disable iff (rst)
        (act_q && act) |=> (addr_q == $past(addr_q)));

endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W       = 6,
    parameter int PGM_CYCLES   = 500,
    parameter int ERASE_CYCLES = 500000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              vpp_hi_i,
    input  wr_evt_t           evt_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    output mode_e             mode_o,
    output logic              pgm_fire_o,
    output logic              erase_fire_o,
    output logic [ADDR_W-1:0] op_addr_o,
    output byte_t             op_data_o
);

    localparam int LIMIT = (PGM_CYCLES > ERASE_CYCLES) ? PGM_CYCLES : ERASE_CYCLES;
    localparam int TW    = $clog2(LIMIT + 1);
    localparam logic [TW-1:0] PGM_LOAD   = TW'(PGM_CYCLES - 1);
    localparam logic [TW-1:0] ERASE_LOAD = TW'(ERASE_CYCLES - 1);

    mode_e             mode_q;
    logic [TW-1:0]     cnt_q;
    logic [ADDR_W-1:0] op_addr_q;
    byte_t             op_data_q;
    logic              accept;
    logic              in_pulse;
    logic              timer_done;

    assign accept     = evt_i.valid & vpp_hi_i;
    assign in_pulse   = (mode_q == M_PGM_PULSE) || (mode_q == M_ERASE_PULSE);
    assign timer_done = in_pulse && (cnt_q == '0) && vpp_hi_i && !accept;

    assign pgm_fire_o   = timer_done && (mode_q == M_PGM_PULSE);
    assign erase_fire_o = timer_done && (mode_q == M_ERASE_PULSE);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q    <= M_READ;
            cnt_q     <= '0;
            op_addr_q <= '0;
            op_data_q <= '0;
        end else if (!vpp_hi_i) begin
            mode_q <= M_READ;
        end else if (accept) begin
            op_addr_q <= wr_addr_i;
            case (mode_q)
                M_PGM_ARM: begin
                    op_data_q <= evt_i.data;
                    cnt_q     <= PGM_LOAD;
                    mode_q    <= M_PGM_PULSE;
                end
                M_ERASE_ARM: begin
                    if (evt_i.data == CMD_ERASE) begin
                        cnt_q  <= ERASE_LOAD;
                        mode_q <= M_ERASE_PULSE;
                    end else begin
                        mode_q <= decode_cmd(evt_i.data);
                    end
                end
                default: mode_q <= decode_cmd(evt_i.data);
            endcase
        end else if (in_pulse) begin
            if (cnt_q == '0)
                mode_q <= (mode_q == M_PGM_PULSE) ? M_PGM_HOLD : M_ERASE_HOLD;
            else
                cnt_q <= cnt_q - 1'b1;
        end
    end

    assign mode_o    = mode_q;
    assign op_addr_o = op_addr_q;
    assign op_data_o = op_data_q;

    // R3: losing the high voltage forces read mode
    a_r3_lockout: assert property (@(posedge clk) disable iff (rst)
        !vpp_hi_i |=> (mode_q == M_READ));

    // R6: an armed erase followed by another code never starts a pulse
    a_r6_erase_needs_repeat: assert property (@(posedge clk) disable iff (rst)
        (mode_q == M_ERASE_ARM && accept && evt_i.data != CMD_ERASE)
        |=> (mode_q != M_ERASE_PULSE));

    // R8: the stop timer ends the pulse by itself
    a_r8_stop_timer: assert property (@(posedge clk) disable iff (rst)
        (in_pulse && cnt_q == '0 && vpp_hi_i && !evt_i.valid)
        |=> (mode_q == M_PGM_HOLD || mode_q == M_ERASE_HOLD));

    // R8: a pulse acts on the array once
    a_r8_fire_once: assert property (@(posedge clk) disable iff (rst)
        (pgm_fire_o || erase_fire_o) |=> !(pgm_fire_o || erase_fire_o));

endmodule

// File: rtl/flash_cell_array.sv
module flash_cell_array
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              erase_i,
    input  logic              pgm_i,
    input  logic [ADDR_W-1:0] pgm_addr_i,
    input  byte_t             pgm_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output byte_t             rd_data_o
);

    localparam int DEPTH = 1 << ADDR_W;

    byte_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst || erase_i) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
        end else if (pgm_i) begin
            mem[pgm_addr_i] <= mem[pgm_addr_i] & pgm_data_i;
        end
    end

    assign rd_data_o = mem[rd_addr_i];

    // R5: a program pulse only clears bits of the target byte
    a_r5_and_merge: assert property (@(posedge clk) disable iff (rst)
        (pgm_i && !erase_i) |=>
        (mem[$past(pgm_addr_i)] == ($past(pgm_data_i) & $past(mem[pgm_addr_i]))));

    // R7: erase fills the array with ones
    a_r7_erase_fill: assert property (@(posedge clk) disable iff (rst)
        erase_i |=> (mem[0] == 8'hFF && mem[DEPTH-1] == 8'hFF));

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
    import flash_cmd_pkg::*;
#(
    parameter int    ADDR_W       = 6,
    parameter int    PGM_CYCLES   = 500,
    parameter int    ERASE_CYCLES = 500000,
    parameter byte_t MFR_CODE     = 8'hA7,
    parameter byte_t DEV_CODE     = 8'h3C
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [7:0]        data_i,
    input  logic              ce_n_i,
    input  logic              we_n_i,
    input  logic              oe_n_i,
    input  logic              vpp_hi_i,
    output logic [7:0]        data_o,
    output logic              data_oe_o
);

    wr_evt_t           evt;
    logic [ADDR_W-1:0] wr_addr;
    mode_e             mode;
    logic              pgm_fire;
    logic              erase_fire;
    logic [ADDR_W-1:0] op_addr;
    byte_t             op_data;
    logic [ADDR_W-1:0] rd_addr;
    byte_t             rd_data;

    flash_wr_capture #(.ADDR_W(ADDR_W)) u_capture (
        .clk    (clk),
        .rst    (rst),
        .addr_i (addr_i),
        .data_i (data_i),
        .ce_n_i (ce_n_i),
        .we_n_i (we_n_i),
        .evt_o  (evt),
        .addr_o (wr_addr)
    );

    flash_cmd_fsm #(
        .ADDR_W       (ADDR_W),
        .PGM_CYCLES   (PGM_CYCLES),
        .ERASE_CYCLES (ERASE_CYCLES)
    ) u_fsm (
        .clk          (clk),
        .rst          (rst),
        .vpp_hi_i     (vpp_hi_i),
        .evt_i        (evt),
        .wr_addr_i    (wr_addr),
        .mode_o       (mode),
        .pgm_fire_o   (pgm_fire),
        .erase_fire_o (erase_fire),
        .op_addr_o    (op_addr),
        .op_data_o    (op_data)
    );

    assign rd_addr = is_verify(mode) ? op_addr : addr_i;

    flash_cell_array #(.ADDR_W(ADDR_W)) u_array (
        .clk        (clk),
        .rst        (rst),
        .erase_i    (erase_fire),
        .pgm_i      (pgm_fire),
        .pgm_addr_i (op_addr),
        .pgm_data_i (op_data),
        .rd_addr_i  (rd_addr),
        .rd_data_o  (rd_data)
    );

    assign data_oe_o = ~ce_n_i & ~oe_n_i & we_n_i;

    always_comb begin
        data_o = 8'h00;
        if (data_oe_o) begin
            if (mode == M_IDENT) data_o = addr_i[0] ? DEV_CODE : MFR_CODE;
            else                 data_o = rd_data;
        end
    end

    // R2: nothing is driven while a write strobe is low
    a_r2_quiet_on_write: assert property (@(posedge clk) disable iff (rst)
        !we_n_i |-> (!data_oe_o && data_o == 8'h00));

endmodule

// File: tb/test_flash_cmd_ctrl.sv
`timescale 1ns/1ps
module test_flash_cmd_ctrl;

    localparam int AW  = 4;
    localparam int PGM = 20;
    localparam int ERS = 40;
    localparam logic [7:0] MFR = 8'hA7;
    localparam logic [7:0] DEV = 8'h3C;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [7:0]    din = '0;
    logic          ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, vpp = 1'b1;
    logic [7:0]    dout;
    logic          doe;

    int checks = 0;
    int errors = 0;
    logic mon_req = 1'b0;

    logic [7:0] q_data[$];
    logic       q_oe[$];
    string      q_tag[$];

    always #10 clk = ~clk;

    flash_cmd_ctrl #(
        .ADDR_W(AW), .PGM_CYCLES(PGM), .ERASE_CYCLES(ERS),
        .MFR_CODE(MFR), .DEV_CODE(DEV)
    ) i_flash_cmd_ctrl (
        .clk(clk), .rst(rst), .addr_i(addr), .data_i(din),
        .ce_n_i(ce_n), .we_n_i(we_n), .oe_n_i(oe_n), .vpp_hi_i(vpp),
        .data_o(dout), .data_oe_o(doe)
    );

    // monitor: pops one expected item per requested sample
    always @(negedge clk) begin
        if (mon_req && q_data.size() > 0) begin
            logic [7:0] e_d;
            logic       e_oe;
            string      tg;
            e_d  = q_data.pop_front();
            e_oe = q_oe.pop_front();
            tg   = q_tag.pop_front();
            checks++;
            if (dout !== e_d || doe !== e_oe) begin
                errors++;
                $display("FAIL %s actual data=%02h oe=%0b expected data=%02h oe=%0b",
                         tg, dout, doe, e_d, e_oe);
            end
        end
    end

    task automatic push(input logic [7:0] d, input logic oe, input string tg);
        q_data.push_back(d);
        q_oe.push_back(oe);
        q_tag.push_back(tg);
        mon_req = 1'b1;
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [7:0] e, input string tg);
        @(posedge clk); #1;
        addr = a; ce_n = 1'b0; oe_n = 1'b0;
        push(e, 1'b1, tg);
        @(posedge clk); #1;
        mon_req = 1'b0; oe_n = 1'b1; ce_n = 1'b1;
    endtask

    task automatic rd_off(input logic ce, input logic oe, input string tg);
        @(posedge clk); #1;
        addr = 3; ce_n = ce; oe_n = oe;
        push(8'h00, 1'b0, tg);
        @(posedge clk); #1;
        mon_req = 1'b0; oe_n = 1'b1; ce_n = 1'b1;
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        addr = a; din = d; ce_n = 1'b0;
        @(posedge clk); #1;
        we_n = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        we_n = 1'b1; ce_n = 1'b1;
        repeat (3) @(posedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic run_all();
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R1 / R2
        rd(3, 8'hFF, "R1 reset read");
        rd(0, 8'hFF, "R1 reset read addr0");
        rd_off(1'b1, 1'b0, "R2 standby");
        rd_off(1'b0, 1'b1, "R2 output disabled");
        // R5 / R8 program
        wr(0, 8'h40); wr(3, 8'h5A);
        rd(3, 8'hFF, "R8 unchanged mid pulse");
        idle(PGM + 5);
        rd(3, 8'h5A, "R5 programmed");
        rd(4, 8'hFF, "R5 neighbour untouched");
        wr(0, 8'h40); wr(3, 8'h0F); idle(PGM + 5);
        rd(3, 8'h0A, "R5 AND merge");
        // R8 abort by early verify, R9 verify address
        wr(0, 8'h40); wr(5, 8'h00); wr(5, 8'hC0);
        rd(9, 8'hFF, "R8 aborted pulse, R9 verify byte");
        idle(PGM + 5);
        wr(0, 8'h00);
        rd(5, 8'hFF, "R8 abort left byte");
        wr(0, 8'h40); wr(6, 8'h33); idle(PGM + 5);
        wr(6, 8'hC0);
        rd(2, 8'h33, "R9 program verify");
        wr(0, 8'hFF);
        // R4 chip-enable controlled write, late address and data
        wr(0, 8'h40);
        @(posedge clk); #1;
        addr = 1; din = 8'hC3; we_n = 1'b0;
        @(posedge clk); #1;
        addr = 9; ce_n = 1'b0;
        @(posedge clk); #1;
        addr = 2; din = 8'hE1;
        @(posedge clk); #1;
        ce_n = 1'b1; we_n = 1'b1; din = 8'h00;
        idle(PGM + 8);
        rd(9, 8'hE1, "R4 address at later fall, data at end");
        rd(2, 8'hFF, "R4 mid-cycle address ignored");
        rd(1, 8'hFF, "R4 early address ignored");
        // R3 lockout
        vpp = 1'b0;
        wr(0, 8'h40); wr(10, 8'h00); idle(PGM + 5);
        vpp = 1'b1;
        rd(10, 8'hFF, "R3 write ignored without vpp");
        wr(0, 8'h90);
        rd(0, MFR, "R10 maker code");
        rd(1, DEV, "R10 device code");
        vpp = 1'b0; idle(2); #1 vpp = 1'b1;
        rd(1, 8'hFF, "R3 vpp drop returns to read");
        // R11
        wr(0, 8'h90); wr(0, 8'h55);
        rd(0, 8'hFF, "R11 unknown code reads array");
        wr(0, 8'h90); wr(0, 8'hFF);
        rd(3, 8'h0A, "R11 reset code reads array");
        // erase verify from read mode
        wr(0, 8'h40); wr(12, 8'h44); idle(PGM + 5);
        wr(0, 8'h00);
        wr(12, 8'hA0);
        rd(0, 8'h44, "R9 erase verify byte");
        // R6 broken erase sequence
        wr(0, 8'h20); wr(0, 8'h90);
        rd(0, MFR, "R6 second code decoded fresh");
        wr(0, 8'h00); idle(ERS + 5);
        rd(3, 8'h0A, "R6 no erase");
        rd(12, 8'h44, "R6 no erase addr12");
        // R7 erase
        wr(0, 8'h20); wr(0, 8'h20);
        rd(3, 8'h0A, "R8 erase pulse running");
        idle(ERS + 5);
        rd(3, 8'hFF, "R7 erased addr3");
        rd(6, 8'hFF, "R7 erased addr6");
        rd(9, 8'hFF, "R7 erased addr9");
        wr(12, 8'hA0);
        rd(0, 8'hFF, "R7 R9 erase verify after erase");
        idle(3);
    endtask

    initial begin
        fork
            run_all();
            begin
                idle(100000);
                errors++;
                $display("FAIL R1 watchdog actual=timeout expected=completion");
            end
        join_any
        disable fork;
        if (q_data.size() != 0) begin
            errors++;
            $display("FAIL R1 unsampled items actual=%0d expected=0", q_data.size());
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule